// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block sits on the host side of a three-line serial link to a register-based peripheral. It carries out one single-byte register read or write per request. A one-cycle start strobe supplies a read/write select, a 7-bit register address and, for writes, one byte of data. The block then drives the chip-enable, serial-clock and data lines through the whole transaction. When the transaction is over it raises a one-cycle done pulse. After a read, the returned byte is available on a held output.

The data line is bidirectional on the board. At the block edge it appears as an output value, an output enable and an input sample. Line timing is built from a delay unit that lasts `UNIT_CYC` system clock cycles. Every line phase lasts exactly one unit, so the length of each transaction is fixed and known ahead of time. The first byte on the wire is the address byte: bit 7 is the write flag and bits 6:0 hold the register address. A write sends the data byte after it. A read lets go of the data line and clocks the peripheral's byte in.

Top module: `tw_reg_master`

## Requirements
- R1: While reset is held, chip enable, serial clock, data output and data output enable are low, the done pulse is low and the read data output is 0.
- R2: Chip enable rises while the clock and the data output are low and the data output enable is high. The first clock rise comes exactly 2*UNIT_CYC cycles after chip enable rises: one setup unit, then one unit of data setup for the first bit.
- R3: The first 8 bits clocked out form the address byte, most significant bit first. Bit 7 is 1 for a write and 0 for a read, and bits 6:0 are the register address. The data output stays stable while the clock is high.
- R4: Every high phase of the serial clock lasts exactly UNIT_CYC cycles, and the clock is only ever high while chip enable is high.
- R5: A write clocks out the data byte most significant bit first after the address byte. Chip enable stays high for exactly 50*UNIT_CYC cycles: 1 setup unit, 24 units for the address byte, 1 gap unit and 24 units for the data byte.
- R6: A read keeps the data output enable low whenever the clock is high during the 8 read pulses. It samples the input after each falling edge and returns the byte most significant bit first. Chip enable stays high for exactly 41*UNIT_CYC cycles.
- R7: When chip enable falls, the clock and the data output are low. The done pulse comes one unit later, 51*UNIT_CYC cycles after the accepting edge for a write and 42*UNIT_CYC for a read.
- R8: The done pulse is high for exactly one cycle per transaction.
- R9: A start strobe that arrives while a transaction is in progress is ignored. No second transaction and no second done pulse follow from it.
- R10: The read data output changes only together with a done pulse, and a write transaction leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | One-cycle request strobe, taken only when idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte from the last read, held |
| rsp_done | output | 1 | One-cycle end-of-transaction pulse |
| line_ce | output | 1 | Chip enable to the peripheral |
| line_sclk | output | 1 | Serial clock to the peripheral |
| line_sdo | output | 1 | Data line value when driven |
| line_sdo_oe | output | 1 | Data line output enable |
| line_sdi | input | 1 | Data line sampled value |

## Verification
Every phase is a whole number of units, so each result falls on a fixed cycle counted from the edge that accepts the start strobe. The first clock rise comes 2 units after chip enable rises. Each clock high phase lasts 1 unit. Chip enable stays high for 50 units on a write and 41 on a read, and done follows 1 unit after chip enable falls. The bench drives and samples on the falling system clock edge and counts those edges from the accepting edge, so each of these durations is compared against its exact expected count rather than a window. A peripheral model inside the bench decodes the bytes on rising serial clock edges and returns read bits during the high phase, well before the master samples them at the end of the following low unit.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ABIT,
      ST_GAP,
      ST_WBIT,
      ST_RBIT,
      ST_TAIL
   } tw_state_t;
endpackage

// File: rtl/tw_unit_timer.sv
module tw_unit_timer #(
   parameter int UNIT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic unit_end
);
   localparam int CNT_W = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(UNIT_CYC - 1);

   generate
      if (UNIT_CYC < 1) begin : g_bad_unit
         $error("tw_unit_timer: UNIT_CYC must be at least 1");
      end
      if (UNIT_CYC == 1) begin : g_single
         assign unit_end = run;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign unit_end = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/tw_seq.sv
module tw_seq
   import tw_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_end,
   input  logic              req_start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              line_sdi,
   output logic              busy,
   output logic              line_ce,
   output logic              line_sclk,
   output logic              line_sdo,
   output logic              line_sdo_oe,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done
);
   localparam int HDR_W = ADDR_W + 1;
   localparam int TX_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
   localparam int MAXB  = TX_W;
   localparam int BIT_W = $clog2(MAXB);
   localparam logic [BIT_W-1:0] HDR_LAST  = BIT_W'(HDR_W - 1);
   localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_W - 1);

   tw_state_t         state;
   logic [1:0]        ph;
   logic [BIT_W-1:0]  bitn;
   logic [TX_W-1:0]   tx;
   logic [DATA_W-1:0] rx;
   logic [DATA_W-1:0] wd;
   logic              is_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ph        <= '0;
         bitn      <= '0;
         tx        <= '0;
         rx        <= '0;
         wd        <= '0;
         is_wr     <= 1'b0;
         rsp_rdata <= '0;
         rsp_done  <= 1'b0;
      end else begin
         rsp_done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_start) begin
                  state <= ST_SETUP;
                  tx    <= TX_W'({req_write, req_addr}) << (TX_W - HDR_W);
                  wd    <= req_wdata;
                  is_wr <= req_write;
                  ph    <= '0;
                  bitn  <= '0;
               end
            end
            ST_SETUP: if (unit_end) state <= ST_ABIT;
            ST_GAP:   if (unit_end) state <= ST_WBIT;
            ST_ABIT, ST_WBIT: begin
               if (unit_end) begin
                  if (ph == 2'd2) begin
                     ph <= '0;
                     tx <= tx << 1;
                     if (state == ST_ABIT && bitn == HDR_LAST) begin
                        bitn <= '0;
                        if (is_wr) begin
                           state <= ST_GAP;
                           tx    <= TX_W'(wd) << (TX_W - DATA_W);
                        end else begin
                           state <= ST_RBIT;
                        end
                     end else if (state == ST_WBIT && bitn == DATA_LAST) begin
                        bitn  <= '0;
                        state <= ST_TAIL;
                     end else begin
                        bitn <= bitn + 1'b1;
                     end
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
            end
            ST_RBIT: begin
               if (unit_end) begin
                  if (ph == 2'd1) begin
                     ph <= '0;
                     rx <= {rx[DATA_W-2:0], line_sdi};
                     if (bitn == DATA_LAST) begin
                        bitn  <= '0;
                        state <= ST_TAIL;
                     end else begin
                        bitn <= bitn + 1'b1;
                     end
                  end else begin
                     ph <= 2'd1;
                  end
               end
            end
            ST_TAIL: begin
               if (unit_end) begin
                  state    <= ST_IDLE;
                  rsp_done <= 1'b1;
                  if (!is_wr) rsp_rdata <= rx;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy        = (state != ST_IDLE);
      line_ce     = (state != ST_IDLE) && (state != ST_TAIL);
      line_sclk   = (((state == ST_ABIT) || (state == ST_WBIT)) && (ph == 2'd1))
                 || ((state == ST_RBIT) && (ph == 2'd0));
      line_sdo    = ((state == ST_ABIT) || (state == ST_WBIT) || (state == ST_GAP))
                    ? tx[TX_W-1] : 1'b0;
      line_sdo_oe = (state != ST_IDLE) && (state != ST_RBIT);
   end
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master #(
   parameter int UNIT_CYC = 4,
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              line_ce,
   output logic              line_sclk,
   output logic              line_sdo,
   output logic              line_sdo_oe,
   input  logic              line_sdi
);
   generate
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_width
         $error("tw_reg_master: ADDR_W must be >= 1 and DATA_W >= 2");
      end
   endgenerate

   logic unit_end;
   logic busy;

   tw_unit_timer #(.UNIT_CYC(UNIT_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .unit_end (unit_end)
   );

   tw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .unit_end    (unit_end),
      .req_start   (req_start),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .line_sdi    (line_sdi),
      .busy        (busy),
      .line_ce     (line_ce),
      .line_sclk   (line_sclk),
      .line_sdo    (line_sdo),
      .line_sdo_oe (line_sdo_oe),
      .rsp_rdata   (rsp_rdata),
      .rsp_done    (rsp_done)
   );
endmodule

// File: rtl/tw_reg_master_chk.sv
module tw_reg_master_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_done,
   input logic              line_ce,
   input logic              line_sclk,
   input logic              line_sdo
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R8
   AST_SCLK_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      line_sclk |-> line_ce); // R4
   AST_QUIET_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_ce |-> (!line_sclk && !line_sdo)); // R7
   AST_CE_RISE_LOW_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_ce) |-> (!line_sclk && !line_sdo)); // R2
   AST_SDO_HELD_HIGH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (line_sclk && $past(line_sclk)) |-> $stable(line_sdo)); // R3
   AST_RDATA_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_rdata) |-> rsp_done); // R10
endmodule

bind tw_reg_master tw_reg_master_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rsp_rdata (rsp_rdata),
   .rsp_done  (rsp_done),
   .line_ce   (line_ce),
   .line_sclk (line_sclk),
   .line_sdo  (line_sdo)
);

// File: tb/tw_reg_master_tb.sv
module tw_reg_master_tb;
   localparam int CLK_PERIOD = 10;
   localparam int UNIT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_start = 1'b0;
   logic       req_write = 1'b0;
   logic [6:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic [7:0] rsp_rdata;
   logic       rsp_done;
   logic       line_ce, line_sclk, line_sdo, line_sdo_oe;
   logic       line_sdi = 1'b0;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tw_reg_master #(.UNIT_CYC(UNIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .rsp_done(rsp_done), .line_ce(line_ce), .line_sclk(line_sclk),
      .line_sdo(line_sdo), .line_sdo_oe(line_sdo_oe), .line_sdi(line_sdi)
   );

   // Peripheral model and line monitor, sampled on the falling edge
   logic [7:0] pmem [128];
   logic prev_ce = 1'b0, prev_sclk = 1'b0;
   int   idx, first_rise, hi_len, bitk, ce_len, hi_viol, oe_viol, end_bad, txn_cnt, setup_bad;
   logic [7:0] abyte, dbyte;

   initial begin
      for (int i = 0; i < 128; i++) pmem[i] = 8'h00;
      idx = 0; first_rise = -1; hi_len = 0; bitk = 0; ce_len = 0; hi_viol = 0;
      oe_viol = 0; end_bad = 0; txn_cnt = 0; setup_bad = 0; abyte = 0; dbyte = 0;
   end

   always @(negedge clk) begin
      logic [7:0] tmp;
      if (line_ce && !prev_ce) begin
         idx = 0; ce_len = 0; first_rise = -1; bitk = 0; hi_len = 0;
         if (line_sclk || line_sdo || !line_sdo_oe) setup_bad++;
      end
      if (line_ce) ce_len++;
      if (line_sclk && !prev_sclk) begin
         if (first_rise < 0) first_rise = idx;
         if (bitk < 8) abyte = {abyte[6:0], line_sdo};
         else if (abyte[7]) dbyte = {dbyte[6:0], line_sdo};
         else begin
            tmp = pmem[abyte[6:0]];
            line_sdi = tmp[15 - bitk];
         end
         bitk++;
      end
      if (line_sclk) begin
         hi_len++;
         if (bitk > 8 && !abyte[7] && line_sdo_oe) oe_viol++;
      end else if (prev_sclk) begin
         if (hi_len != UNIT) hi_viol++;
         hi_len = 0;
      end
      if (!line_ce && prev_ce) begin
         if (line_sclk || line_sdo) end_bad++;
         if (abyte[7]) pmem[abyte[6:0]] = dbyte;
         txn_cnt++;
      end
      idx++;
      prev_ce = line_ce;
      prev_sclk = line_sclk;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // {write, addr[6:0], wdata[7:0], expected rdata[7:0]}
   localparam logic [23:0] VEC [8] = '{
      {1'b1, 7'h05, 8'hA5, 8'h00},
      {1'b1, 7'h7F, 8'h3C, 8'h00},
      {1'b1, 7'h00, 8'h81, 8'h00},
      {1'b0, 7'h05, 8'h00, 8'hA5},
      {1'b0, 7'h7F, 8'h00, 8'h3C},
      {1'b1, 7'h12, 8'hFF, 8'h00},
      {1'b0, 7'h00, 8'h00, 8'h81},
      {1'b0, 7'h12, 8'h00, 8'hFF}
   };

   task automatic run_txn(input logic w, input logic [6:0] a, input logic [7:0] d,
                          input logic [7:0] exp_rd);
      int lat;
      logic [7:0] rd_before;
      rd_before = rsp_rdata;
      hi_viol = 0; oe_viol = 0; end_bad = 0; setup_bad = 0;
      req_write = w; req_addr = a; req_wdata = d; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      lat = 0;
      while (!rsp_done && lat < 200 * UNIT) begin
         @(negedge clk);
         lat++;
      end
      check(lat == (w ? 51 : 42) * UNIT, "R7 latency", lat, (w ? 51 : 42) * UNIT);
      check(end_bad == 0, "R7 lines low at ce fall", end_bad, 0);
      check(setup_bad == 0, "R2 setup levels", setup_bad, 0);
      check(first_rise == 2 * UNIT, "R2 first clock rise", first_rise, 2 * UNIT);
      check(abyte == {w, a}, "R3 address byte", abyte, {w, a});
      check(hi_viol == 0, "R4 clock high width", hi_viol, 0);
      if (w) begin
         check(dbyte == d, "R5 data byte", dbyte, d);
         check(ce_len == 50 * UNIT, "R5 ce length", ce_len, 50 * UNIT);
         check(rsp_rdata == rd_before, "R10 rdata kept on write", rsp_rdata, rd_before);
      end else begin
         check(rsp_rdata == exp_rd, "R6 read data", rsp_rdata, exp_rd);
         check(ce_len == 41 * UNIT, "R6 ce length", ce_len, 41 * UNIT);
         check(oe_viol == 0, "R6 output enable off", oe_viol, 0);
      end
      @(negedge clk);
      check(!rsp_done, "R8 done one cycle", rsp_done, 0);
   endtask

   initial begin
      int dones, t0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!line_ce && !line_sclk && !line_sdo && !line_sdo_oe, "R1 lines in reset",
            {line_ce, line_sclk, line_sdo, line_sdo_oe}, 0);
      check(!rsp_done && rsp_rdata == 8'h00, "R1 outputs in reset", rsp_rdata, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 8; i++)
         run_txn(VEC[i][23], VEC[i][22:16], VEC[i][15:8], VEC[i][7:0]);

      // R9: start during a busy read must be ignored
      t0 = txn_cnt;
      req_write = 1'b0; req_addr = 7'h05; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      repeat (10 * UNIT) @(negedge clk);
      req_write = 1'b1; req_addr = 7'h33; req_wdata = 8'h77; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      dones = 0;
      repeat (100 * UNIT) begin
         @(negedge clk);
         if (rsp_done) dones++;
      end
      check(dones == 1, "R9 single done", dones, 1);
      check(txn_cnt == t0 + 1, "R9 single transaction", txn_cnt, t0 + 1);
      check(pmem[7'h33] == 8'h00, "R9 ignored write", pmem[7'h33], 0);
      check(rsp_rdata == 8'hA5, "R9 first read completed", rsp_rdata, 8'hA5);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule